// File: doc/BRIEF.md
# I2C Bus Clock-Stall Timeout Detector

This block watches the filtered SCL line of an I2C or SMBus interface and reports when the clock has stayed at one level for too long. It follows the bus state from START and STOP conditions on SCL and SDA, and it only counts while the bus is occupied. A reference tick is derived from the block clock by a power-of-two prescaler. The tick drives a clock-enable on the counter and is never used as a clock.

Software configures the block with level inputs:
- a function enable;
- a long or short period select;
- separate enables for counting during SCL low and during SCL high;
- an interrupt enable.

When the selected period has elapsed without a break, a sticky timeout flag is raised. Software clears the flag by writing 0 to it. An interrupt request follows the flag, gated by its enable.

Three state machines carry the behaviour:
- Bus monitor: BUS_FREE goes to BUS_BUSY on a START, and BUS_BUSY goes back to BUS_FREE on a STOP.
- Level timer: it is in TM_OFF while the function is disabled and in TM_FREE while the bus is free. Otherwise it is in TM_LOW or TM_HIGH, following the sampled SCL level. Any change of timer state clears the count.
- Flag: FLAG_CLEAR goes to FLAG_RAISED on expiry. FLAG_RAISED goes back to FLAG_CLEAR on a write of 0, unless an expiry happens in the same cycle.

Top module: `i2c_scl_timeout`

## Requirements
- R1: After reset the timeout flag, the interrupt request and the bus-busy output are 0.
- R2: While `tmo_en_i` is 0 the count is held at zero and the flag is never set. After `tmo_en_i` returns to 1, counting starts from zero.
- R3: `short_sel_i` = 0 selects long mode, which expires after 2^LONG_W counted ticks. `short_sel_i` = 1 selects short mode, which expires after 2^SHORT_W counted ticks.
- R4: A low SCL level is counted only when `cnt_low_en_i` is 1.
- R5: A high SCL level is counted only when `cnt_high_en_i` is 1.
- R6: The tick occurs once every 2^`div_sel_i` clocks, and `div_sel_i` ranges from 0 to 7. The prescaler restarts whenever the count is cleared. Counting starts at the first clock edge that samples the level with the bus busy (edge 1), and the flag is set at edge 2^(W+`div_sel_i`)+1, where W is the selected width.
- R7: Any change of the SCL level clears the count, so only an unbroken level can time out.
- R8: A START (SDA falls while SCL is high) sets bus-busy, and a STOP (SDA rises while SCL is high) clears it. No counting happens while the bus is free.
- R9: The flag is sticky. A write strobe with data 0 clears it, and a write with data 1 has no effect.
- R10: An expiry in the same cycle as a clearing write leaves the flag set.
- R11: `tmo_irq_o` is 1 exactly when the flag is 1 and `tmo_irq_en_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tmo_en_i | input | 1 | Timeout function enable |
| short_sel_i | input | 1 | Period select: 0 long, 1 short |
| cnt_low_en_i | input | 1 | Count while SCL is low |
| cnt_high_en_i | input | 1 | Count while SCL is high |
| tmo_irq_en_i | input | 1 | Interrupt request enable |
| div_sel_i | input | CKS_W | Tick prescaler exponent |
| scl_i | input | 1 | Filtered SCL level |
| sda_i | input | 1 | Filtered SDA level |
| flag_wr_i | input | 1 | Software write strobe for the flag |
| flag_wdata_i | input | 1 | Write data for the flag (0 clears) |
| tmo_flag_o | output | 1 | Sticky timeout flag |
| tmo_irq_o | output | 1 | Timeout interrupt request |
| bus_busy_o | output | 1 | Bus occupied between START and STOP |

## Verification
The bench builds the block with LONG_W = 6 and SHORT_W = 4, keeping CKS_W at 3. With these widths the longest timeout is 2^13 clocks. That brings every prescaler setting in both period modes, for both SCL levels, within reach of an exhaustive sweep. Each run checks the exact edge at which the flag rises against 2^(W+div)+1. The same small widths keep the directed corner cases short: a level break one edge before expiry, a clearing write on the expiry edge, and re-enabling while the line is stuck.

// File: rtl/i2c_tmo_pkg.sv
package i2c_tmo_pkg;

    // Bus occupancy as seen from START and STOP conditions
    typedef enum logic [0:0] {
        BUS_FREE = 1'b0,
        BUS_BUSY = 1'b1
    } bus_state_e;

    // Level timer: which level (if any) is being timed
    typedef enum logic [1:0] {
        TM_OFF  = 2'd0,
        TM_FREE = 2'd1,
        TM_LOW  = 2'd2,
        TM_HIGH = 2'd3
    } tm_state_e;

    // Counter action chosen each cycle
    typedef enum logic [1:0] {
        CA_HOLD  = 2'd0,
        CA_CLEAR = 2'd1,
        CA_STEP  = 2'd2,
        CA_WRAP  = 2'd3
    } cnt_act_e;

    // Sticky flag
    typedef enum logic [0:0] {
        FLAG_CLEAR  = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_e;

endpackage

// File: rtl/i2c_tmo_prescaler.sv
module i2c_tmo_prescaler #(
    parameter int CKS_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    input  logic [CKS_W-1:0] div_sel_i,
    output logic             tick_o
);
    localparam int DIV_W = (1 << CKS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Bit g of the mask is set when the exponent exceeds g
    for (genvar g = 0; g < DIV_W; g++) begin : g_mask
        assign mask[g] = (div_sel_i > CKS_W'(g));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= '0;
        end else if (restart_i) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    always_comb begin
        tick_o = ((div_q & mask) == mask);
    end

endmodule

// File: rtl/i2c_tmo_busmon.sv
module i2c_tmo_busmon
    import i2c_tmo_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic busy_o
);
    bus_state_e state_q, state_d;
    logic       scl_q, sda_q;
    logic       start_seen, stop_seen;

    always_comb begin
        start_seen = scl_i & scl_q & sda_q & ~sda_i;
        stop_seen  = scl_i & scl_q & ~sda_q & sda_i;
    end

    // State register and line history
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= BUS_FREE;
            scl_q   <= 1'b1;
            sda_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            scl_q   <= scl_i;
            sda_q   <= sda_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_FREE: if (start_seen) state_d = BUS_BUSY;
            BUS_BUSY: if (stop_seen)  state_d = BUS_FREE;
        endcase
    end

    always_comb begin
        busy_o = (state_q == BUS_BUSY);
    end

endmodule

// File: rtl/i2c_tmo_counter.sv
module i2c_tmo_counter
    import i2c_tmo_pkg::*;
#(
    parameter int LONG_W  = 16,
    parameter int SHORT_W = 14
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic busy_i,
    input  logic scl_i,
    input  logic short_sel_i,
    input  logic low_en_i,
    input  logic high_en_i,
    input  logic tick_i,
    output logic clear_o,
    output logic expire_o
);
    tm_state_e         state_q, state_d;
    cnt_act_e          act;
    logic [LONG_W-1:0] cnt_q;
    logic              level_en;
    logic              at_end;

    // Timer state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= TM_OFF;
        else         state_q <= state_d;
    end

    always_comb begin
        if (!en_i)        state_d = TM_OFF;
        else if (!busy_i) state_d = TM_FREE;
        else if (scl_i)   state_d = TM_HIGH;
        else              state_d = TM_LOW;
    end

    // Action and outputs
    always_comb begin
        unique case (state_d)
            TM_LOW:  level_en = low_en_i;
            TM_HIGH: level_en = high_en_i;
            TM_OFF, TM_FREE: level_en = 1'b0;
        endcase
        at_end = short_sel_i ? (&cnt_q[SHORT_W-1:0]) : (&cnt_q);
        if (state_d == TM_OFF || state_d == TM_FREE || state_d != state_q) begin
            act = CA_CLEAR;
        end else if (tick_i && level_en) begin
            act = at_end ? CA_WRAP : CA_STEP;
        end else begin
            act = CA_HOLD;
        end
        clear_o  = (act == CA_CLEAR);
        expire_o = (act == CA_WRAP);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            unique case (act)
                CA_CLEAR, CA_WRAP: cnt_q <= '0;
                CA_STEP:           cnt_q <= cnt_q + LONG_W'(1);
                CA_HOLD:           cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/i2c_scl_timeout.sv
module i2c_scl_timeout
    import i2c_tmo_pkg::*;
#(
    parameter int LONG_W  = 16,
    parameter int SHORT_W = 14,
    parameter int CKS_W   = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tmo_en_i,
    input  logic             short_sel_i,
    input  logic             cnt_low_en_i,
    input  logic             cnt_high_en_i,
    input  logic             tmo_irq_en_i,
    input  logic [CKS_W-1:0] div_sel_i,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             flag_wr_i,
    input  logic             flag_wdata_i,
    output logic             tmo_flag_o,
    output logic             tmo_irq_o,
    output logic             bus_busy_o
);
    logic        tmo_tick;
    logic        tmo_clear;
    logic        tmo_expire;
    logic        flag_wipe;
    flag_state_e flag_q, flag_d;

    i2c_tmo_busmon u_busmon (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .busy_o (bus_busy_o)
    );

    i2c_tmo_prescaler #(.CKS_W(CKS_W)) u_presc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (tmo_clear),
        .div_sel_i (div_sel_i),
        .tick_o    (tmo_tick)
    );

    i2c_tmo_counter #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_cnt (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (tmo_en_i),
        .busy_i      (bus_busy_o),
        .scl_i       (scl_i),
        .short_sel_i (short_sel_i),
        .low_en_i    (cnt_low_en_i),
        .high_en_i   (cnt_high_en_i),
        .tick_i      (tmo_tick),
        .clear_o     (tmo_clear),
        .expire_o    (tmo_expire)
    );

    // Flag state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= FLAG_CLEAR;
        else         flag_q <= flag_d;
    end

    always_comb begin
        flag_wipe = flag_wr_i & ~flag_wdata_i;
        flag_d    = flag_q;
        unique case (flag_q)
            FLAG_CLEAR:  if (tmo_expire) flag_d = FLAG_RAISED;
            FLAG_RAISED: if (flag_wipe && !tmo_expire) flag_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        tmo_flag_o = (flag_q == FLAG_RAISED);
        tmo_irq_o  = tmo_flag_o & tmo_irq_en_i;
    end

endmodule

// File: rtl/i2c_tmo_checker.sv
module i2c_tmo_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic tmo_en,
    input logic scl,
    input logic low_en,
    input logic high_en,
    input logic flag_wr,
    input logic flag_wdata,
    input logic flag,
    input logic irq,
    input logic busy,
    input logic expire
);
    a_r2_disabled_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tmo_en |=> !$rose(flag));

    a_r4_low_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!low_en && !scl) |=> !$rose(flag));

    a_r5_high_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!high_en && scl) |=> !$rose(flag));

    a_r7_edge_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scl != $past(scl)) |=> !$rose(flag));

    a_r8_free_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy |=> !$rose(flag));

    a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag && !(flag_wr && !flag_wdata)) |=> flag);

    a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_wr && !flag_wdata && !expire) |=> !flag);

    a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire |=> flag);

    a_r11_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq |-> flag);

endmodule

bind i2c_scl_timeout i2c_tmo_checker u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tmo_en     (tmo_en_i),
    .scl        (scl_i),
    .low_en     (cnt_low_en_i),
    .high_en    (cnt_high_en_i),
    .flag_wr    (flag_wr_i),
    .flag_wdata (flag_wdata_i),
    .flag       (tmo_flag_o),
    .irq        (tmo_irq_o),
    .busy       (bus_busy_o),
    .expire     (tmo_expire)
);

// File: tb/tb_i2c_scl_timeout.sv
`timescale 1ns/1ps
module tb_i2c_scl_timeout;
    localparam int LW = 6;
    localparam int SW = 4;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, short_sel = 1'b0, low_en = 1'b0, high_en = 1'b0, irq_en = 1'b0;
    logic [CW-1:0] div_sel = '0;
    logic scl = 1'b1, sda = 1'b1;
    logic fwr = 1'b0, fwd = 1'b0;
    logic flag, irq, busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_scl_timeout #(.LONG_W(LW), .SHORT_W(SW), .CKS_W(CW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .tmo_en_i(en), .short_sel_i(short_sel),
        .cnt_low_en_i(low_en), .cnt_high_en_i(high_en), .tmo_irq_en_i(irq_en),
        .div_sel_i(div_sel), .scl_i(scl), .sda_i(sda), .flag_wr_i(fwr),
        .flag_wdata_i(fwd), .tmo_flag_o(flag), .tmo_irq_o(irq), .bus_busy_o(busy)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Brings the bus to free with a STOP from any line state
    task automatic bus_release();
        scl = 1'b0; step(1);
        sda = 1'b0; step(1);
        scl = 1'b1; step(1);
        sda = 1'b1; step(1);
    endtask

    task automatic clear_flag();
        fwr = 1'b1; fwd = 1'b0; step(1);
        fwr = 1'b0;
    endtask

    task automatic start_bus();
        sda = 1'b0; step(1);
    endtask

    task automatic timed_run(input int c, input bit sm, input bit lvl_low);
        int w;
        int n;
        en = 1'b1; low_en = 1'b1; high_en = 1'b1;
        div_sel = CW'(c); short_sel = sm; irq_en = c[0];
        bus_release();
        clear_flag();
        start_bus();
        if (lvl_low) scl = 1'b0;
        w = sm ? SW : LW;
        n = 1 << (w + c);
        step(n);
        chk($sformatf("R6 R3 before expiry div=%0d short=%0d low=%0d", c, sm, lvl_low), flag, 1'b0);
        step(1);
        chk($sformatf("R6 R3 at expiry div=%0d short=%0d low=%0d", c, sm, lvl_low), flag, 1'b1);
        chk($sformatf("R11 irq div=%0d", c), irq, c[0]);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1
        chk("R1 flag", flag, 1'b0);
        chk("R1 irq", irq, 1'b0);
        chk("R1 busy", busy, 1'b0);

        // R8: bus free, line stuck low
        en = 1'b1; low_en = 1'b1; high_en = 1'b1; short_sel = 1'b1;
        scl = 1'b0;
        step(64);
        chk("R8 no count while free", flag, 1'b0);
        chk("R8 busy stays free", busy, 1'b0);
        bus_release();
        start_bus();
        chk("R8 START sets busy", busy, 1'b1);
        bus_release();
        chk("R8 STOP clears busy", busy, 1'b0);

        // Exhaustive sweep
        for (int c = 0; c < 8; c++)
            for (int sm = 0; sm < 2; sm++)
                for (int lv = 0; lv < 2; lv++)
                    timed_run(c, sm[0], lv[0]);

        // R2: disabled, then re-enabled while stuck
        div_sel = '0; short_sel = 1'b1; irq_en = 1'b1;
        bus_release(); clear_flag();
        en = 1'b0;
        start_bus();
        scl = 1'b0;
        step(200);
        chk("R2 disabled never sets", flag, 1'b0);
        en = 1'b1;
        step(16);
        chk("R2 restart from zero, before", flag, 1'b0);
        step(1);
        chk("R2 restart from zero, at", flag, 1'b1);

        // R4 off, high counting on
        bus_release(); clear_flag();
        low_en = 1'b0; high_en = 1'b1;
        start_bus();
        scl = 1'b0;
        step(100);
        chk("R4 low not counted", flag, 1'b0);
        scl = 1'b1;
        step(16);
        chk("R5 high counted, before", flag, 1'b0);
        step(1);
        chk("R5 high counted, at", flag, 1'b1);

        // R5 off, low counting on
        bus_release(); clear_flag();
        low_en = 1'b1; high_en = 1'b0;
        start_bus();
        step(100);
        chk("R5 high not counted", flag, 1'b0);
        scl = 1'b0;
        step(16);
        chk("R4 low counted, before", flag, 1'b0);
        step(1);
        chk("R4 low counted, at", flag, 1'b1);

        // R7: level change one edge before expiry
        bus_release(); clear_flag();
        low_en = 1'b1; high_en = 1'b1;
        start_bus();
        scl = 1'b0;
        step(16);
        chk("R7 before first expiry", flag, 1'b0);
        scl = 1'b1;
        step(16);
        chk("R7 rise restarted count", flag, 1'b0);
        scl = 1'b0;
        step(16);
        chk("R7 fall restarted count", flag, 1'b0);
        step(1);
        chk("R7 unbroken level expires", flag, 1'b1);

        // R9: sticky, write 1 ignored, write 0 clears
        fwr = 1'b1; fwd = 1'b1; step(1);
        fwr = 1'b0;
        chk("R9 write 1 ignored", flag, 1'b1);
        clear_flag();
        chk("R9 write 0 clears", flag, 1'b0);
        chk("R11 irq low after clear", irq, 1'b0);

        // R10: clear on the expiry edge
        bus_release(); clear_flag();
        start_bus();
        scl = 1'b0;
        step(16);
        chk("R10 before expiry", flag, 1'b0);
        fwr = 1'b1; fwd = 1'b0; step(1);
        fwr = 1'b0;
        chk("R10 set beats clear", flag, 1'b1);

        // R11: enable gating
        irq_en = 1'b0; #1;
        chk("R11 irq gated off", irq, 1'b0);
        irq_en = 1'b1; #1;
        chk("R11 irq follows flag", irq, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule